// File: doc/BRIEF.md
# Operator Console Controller

This block is the control logic behind the operator panel of a 12-bit minicomputer. It takes the raw panel keys, synchronises and debounces them, and turns each press into a single action. It holds the console address register and the 3-bit instruction-field and data-field registers. It runs memory cycles for examine and deposit, and it drives run, start, halt, single-step and initialise control to the processor.

A lamp multiplexer chooses what the twelve data lamps show: the processor state word, a status word built from CPU flags and the field registers, AC, the console memory-data register, MQ or the bus. The address lamps show the console address and the extended-address lamps show the instruction field. A lock input blocks every key while the switch register stays live. While the processor runs, only halt, clear and the single-step switch have any effect.

Top module: `console_panel`

## Requirements
- R1: Address-load (key bit 0) copies the 12-bit switch register into the console address, which appears on the address lamps; reset clears the console address, both fields, the data register and the run state.
- R2: Extended-load (key bit 1) copies switch vector bits [5:3] into the instruction field and bits [2:0] into the data field. These are bits 6–8 and 9–11 when bit 0 is the MSB.
- R3: Examine (key bit 4) reads memory at address {instruction field, console address}, stores the word in the data register and then adds one to the console address, wrapping from 7777 octal to 0. The request, address and write flag hold steady until acknowledge.
- R4: Deposit (key bit 5) writes the switch register to {instruction field, console address}, places that word in the data register and then adds one to the console address.
- R5: Clear (key bit 2) gives exactly one cycle of cpu_init_o per press and changes no console register.
- R6: Continue (key bit 3) while halted sets the run lamp, gives one cycle of cpu_start_o, and presents the console address on cpu_pc_o.
- R7: With the single-step switch on, continue runs the processor until the first instruction-done pulse, and the run state drops on that pulse.
- R8: Halt (key bit 6) while running keeps the run state high until the next instruction-done pulse, and it drops on that pulse.
- R9: With the lock input high, every key is ignored.
- R10: While running, address-load, extended-load, examine, deposit and continue are ignored, and no memory request is made.
- R11: A key acts once per press however long it is held. A pulse shorter than DEB_CYCLES synchronised cycles does nothing.
- R12: Display code 1 shows, MSB first: link, greater-than, interrupt request, interrupt inhibit, interrupt enable, user mode, instruction field, data field.
- R13: Display codes 0, 2, 3, 4 and 5 show the state word, AC, the data register, MQ and the bus. Codes 6 and 7 show zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sw_i | input | 12 | Switch register |
| key_i | input | 7 | Raw panel keys, bit map per requirements |
| sstep_i | input | 1 | Single-step switch level |
| lock_i | input | 1 | Panel lock |
| disp_sel_i | input | 3 | Data lamp source code |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | 15 | Memory address {field, address} |
| mem_wdata_o | output | 12 | Memory write data |
| mem_rdata_i | input | 12 | Memory read data, valid with ack |
| mem_ack_i | input | 1 | Memory acknowledge |
| cpu_run_o | output | 1 | Processor run enable |
| cpu_start_o | output | 1 | One-cycle start pulse |
| cpu_pc_o | output | 12 | Start address |
| cpu_init_o | output | 1 | One-cycle initialise pulse |
| cpu_instr_done_i | input | 1 | Instruction boundary pulse |
| cpu_state_i | input | 12 | Processor state word |
| cpu_link_i | input | 1 | Link flag |
| cpu_gt_i | input | 1 | Greater-than flag |
| cpu_irq_i | input | 1 | Interrupt request |
| cpu_int_inh_i | input | 1 | Interrupt inhibit |
| cpu_int_en_i | input | 1 | Interrupt enable |
| cpu_user_i | input | 1 | User mode |
| cpu_ac_i | input | 12 | Accumulator |
| cpu_mq_i | input | 12 | Multiplier-quotient |
| cpu_bus_i | input | 12 | Bus data lines |
| data_lamp_o | output | 12 | Data lamps |
| addr_lamp_o | output | 12 | Address lamps (console address) |
| ema_lamp_o | output | 3 | Extended address lamps (instruction field) |
| run_lamp_o | output | 1 | Run lamp |

## Verification
A key becomes a press at most about DEB_CYCLES plus four cycles after it rises. Register loads follow one cycle later, and examine and deposit finish some four cycles after that, with a single-cycle acknowledge. The bench holds each key for twelve cycles and then waits fourteen more before it samples, so every result has settled. Run-state changes land on the clock edge that samples the instruction-done pulse, and the bench checks them two falling edges later. The lamp multiplexer is combinational, so the bench checks it one time step after it changes the selector.

// File: rtl/console_pkg.sv
package console_pkg;
  localparam int KEY_N   = 7;
  localparam int K_ADDR  = 0;
  localparam int K_EXTD  = 1;
  localparam int K_CLEAR = 2;
  localparam int K_CONT  = 3;
  localparam int K_EXAM  = 4;
  localparam int K_DEP   = 5;
  localparam int K_HALT  = 6;

  typedef enum logic [2:0] {
    DSP_STATE  = 3'd0,
    DSP_STATUS = 3'd1,
    DSP_AC     = 3'd2,
    DSP_MD     = 3'd3,
    DSP_MQ     = 3'd4,
    DSP_BUS    = 3'd5
  } disp_e;

  typedef struct packed {
    logic       link;
    logic       gt;
    logic       irq;
    logic       int_inh;
    logic       int_en;
    logic       user;
    logic [2:0] ifield;
    logic [2:0] dfield;
  } status_t;
endpackage

// File: rtl/panel_sync.sv
module panel_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end
  assign q_o = s2_q;
endmodule

// File: rtl/panel_key.sv
module panel_key #(
  parameter int DEB_CYCLES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic press_o
);
  localparam int CW = $clog2(DEB_CYCLES + 1);

  logic          lvl;
  logic          db_q;
  logic [CW-1:0] cnt_q;

  panel_sync #(.W(1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_i),
    .q_o   (lvl)
  );

  // level must differ from the debounced state for DEB_CYCLES cycles in a row
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      db_q    <= 1'b0;
      cnt_q   <= '0;
      press_o <= 1'b0;
    end else begin
      press_o <= 1'b0;
      if (lvl != db_q) begin
        if (cnt_q == CW'(DEB_CYCLES - 1)) begin
          db_q    <= lvl;
          cnt_q   <= '0;
          press_o <= lvl;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        cnt_q <= '0;
      end
    end
  end
endmodule

// File: rtl/panel_mem_seq.sv
module panel_mem_seq #(
  parameter int WORD_W = 12,
  parameter int ADDR_W = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [WORD_W-1:0] data_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  input  logic [WORD_W-1:0] mem_rdata_i,
  input  logic              mem_ack_i
);
  logic              busy_q, we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0] wdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      done_o  <= 1'b0;
      data_o  <= '0;
    end else begin
      done_o <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q  <= 1'b1;
          we_q    <= we_i;
          addr_q  <= addr_i;
          wdata_q <= wdata_i;
        end
      end else if (mem_ack_i) begin
        busy_q <= 1'b0;
        done_o <= 1'b1;
        data_o <= we_q ? wdata_q : mem_rdata_i;
      end
    end
  end

  assign busy_o      = busy_q;
  assign mem_req_o   = busy_q;
  assign mem_we_o    = busy_q & we_q;
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = wdata_q;
endmodule

// File: rtl/panel_lamp_mux.sv
module panel_lamp_mux
  import console_pkg::*;
#(
  parameter int WORD_W = 12
) (
  input  logic [2:0]        sel_i,
  input  logic [WORD_W-1:0] state_i,
  input  logic [WORD_W-1:0] status_i,
  input  logic [WORD_W-1:0] ac_i,
  input  logic [WORD_W-1:0] md_i,
  input  logic [WORD_W-1:0] mq_i,
  input  logic [WORD_W-1:0] bus_i,
  output logic [WORD_W-1:0] lamp_o
);
  always_comb begin
    case (sel_i)
      DSP_STATE:  lamp_o = state_i;
      DSP_STATUS: lamp_o = status_i;
      DSP_AC:     lamp_o = ac_i;
      DSP_MD:     lamp_o = md_i;
      DSP_MQ:     lamp_o = mq_i;
      DSP_BUS:    lamp_o = bus_i;
      default:    lamp_o = '0;
    endcase
  end
endmodule

// File: rtl/console_panel.sv
module console_panel
  import console_pkg::*;
#(
  parameter int WORD_W     = 12,
  parameter int FIELD_W    = 3,
  parameter int DEB_CYCLES = 4,
  localparam int ADDR_W    = FIELD_W + WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] sw_i,
  input  logic [KEY_N-1:0]  key_i,
  input  logic              sstep_i,
  input  logic              lock_i,
  input  logic [2:0]        disp_sel_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  input  logic [WORD_W-1:0] mem_rdata_i,
  input  logic              mem_ack_i,
  output logic              cpu_run_o,
  output logic              cpu_start_o,
  output logic [WORD_W-1:0] cpu_pc_o,
  output logic              cpu_init_o,
  input  logic              cpu_instr_done_i,
  input  logic [WORD_W-1:0] cpu_state_i,
  input  logic              cpu_link_i,
  input  logic              cpu_gt_i,
  input  logic              cpu_irq_i,
  input  logic              cpu_int_inh_i,
  input  logic              cpu_int_en_i,
  input  logic              cpu_user_i,
  input  logic [WORD_W-1:0] cpu_ac_i,
  input  logic [WORD_W-1:0] cpu_mq_i,
  input  logic [WORD_W-1:0] cpu_bus_i,
  output logic [WORD_W-1:0] data_lamp_o,
  output logic [WORD_W-1:0] addr_lamp_o,
  output logic [FIELD_W-1:0] ema_lamp_o,
  output logic              run_lamp_o
);
  logic [KEY_N-1:0]   press;
  logic [1:0]         lvl;
  logic               sstep_s, lock_s;
  logic [WORD_W-1:0]  cma_q, md_q;
  logic [FIELD_W-1:0] if_q, df_q;
  logic               run_q, step_q, halt_pend_q, start_q, init_q;
  logic               seq_busy, seq_done;
  logic [WORD_W-1:0]  seq_data;
  logic               idle, addr_go, extd_go, exam_go, dep_go, cont_go, halt_go, clear_go;
  status_t            status;

  for (genvar k = 0; k < KEY_N; k++) begin : g_key
    panel_key #(.DEB_CYCLES(DEB_CYCLES)) u_key (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .raw_i  (key_i[k]),
      .press_o(press[k])
    );
  end

  panel_sync #(.W(2)) u_lvl_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sstep_i, lock_i}),
    .q_o   (lvl)
  );
  assign sstep_s = lvl[1];
  assign lock_s  = lvl[0];

  // halted, unlocked and no memory cycle in flight or retiring
  assign idle     = !lock_s && !run_q && !seq_busy && !seq_done;
  assign addr_go  = press[K_ADDR] && idle;
  assign extd_go  = press[K_EXTD] && idle;
  assign exam_go  = press[K_EXAM] && idle;
  assign dep_go   = press[K_DEP]  && idle;
  assign cont_go  = press[K_CONT] && idle;
  assign halt_go  = press[K_HALT] && !lock_s && run_q;
  assign clear_go = press[K_CLEAR] && !lock_s;

  panel_mem_seq #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (exam_go || dep_go),
    .we_i       (dep_go),
    .addr_i     ({if_q, cma_q}),
    .wdata_i    (sw_i),
    .busy_o     (seq_busy),
    .done_o     (seq_done),
    .data_o     (seq_data),
    .mem_req_o  (mem_req_o),
    .mem_we_o   (mem_we_o),
    .mem_addr_o (mem_addr_o),
    .mem_wdata_o(mem_wdata_o),
    .mem_rdata_i(mem_rdata_i),
    .mem_ack_i  (mem_ack_i)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cma_q <= '0;
      md_q  <= '0;
      if_q  <= '0;
      df_q  <= '0;
    end else begin
      if (addr_go) cma_q <= sw_i;
      else if (seq_done) begin
        cma_q <= cma_q + 1'b1;
        md_q  <= seq_data;
      end
      if (extd_go) begin
        if_q <= sw_i[2*FIELD_W-1:FIELD_W];
        df_q <= sw_i[FIELD_W-1:0];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q       <= 1'b0;
      step_q      <= 1'b0;
      halt_pend_q <= 1'b0;
      start_q     <= 1'b0;
      init_q      <= 1'b0;
    end else begin
      start_q <= cont_go;
      init_q  <= clear_go;
      if (cont_go) begin
        run_q  <= 1'b1;
        step_q <= sstep_s;
      end else if (run_q && cpu_instr_done_i && (halt_pend_q || step_q || sstep_s)) begin
        run_q       <= 1'b0;
        step_q      <= 1'b0;
        halt_pend_q <= 1'b0;
      end else if (halt_go) begin
        halt_pend_q <= 1'b1;
      end
    end
  end

  assign cpu_run_o   = run_q;
  assign cpu_start_o = start_q;
  assign cpu_pc_o    = cma_q;
  assign cpu_init_o  = init_q;

  always_comb begin
    status.link    = cpu_link_i;
    status.gt      = cpu_gt_i;
    status.irq     = cpu_irq_i;
    status.int_inh = cpu_int_inh_i;
    status.int_en  = cpu_int_en_i;
    status.user    = cpu_user_i;
    status.ifield  = if_q;
    status.dfield  = df_q;
  end

  panel_lamp_mux #(.WORD_W(WORD_W)) u_mux (
    .sel_i   (disp_sel_i),
    .state_i (cpu_state_i),
    .status_i(WORD_W'(status)),
    .ac_i    (cpu_ac_i),
    .md_i    (md_q),
    .mq_i    (cpu_mq_i),
    .bus_i   (cpu_bus_i),
    .lamp_o  (data_lamp_o)
  );

  assign addr_lamp_o = cma_q;
  assign ema_lamp_o  = if_q;
  assign run_lamp_o  = run_q;
endmodule

// File: rtl/console_panel_chk.sv
module console_panel_chk #(
  parameter int WORD_W  = 12,
  parameter int FIELD_W = 3,
  parameter int ADDR_W  = 15
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               mem_req_o,
  input logic               mem_we_o,
  input logic [ADDR_W-1:0]  mem_addr_o,
  input logic               mem_ack_i,
  input logic               cpu_run_o,
  input logic               cpu_start_o,
  input logic               cpu_init_o,
  input logic               cpu_instr_done_i,
  input logic [2:0]         disp_sel_i,
  input logic [WORD_W-1:0]  data_lamp_o,
  input logic [FIELD_W-1:0] ema_lamp_o,
  input logic               cpu_link_i,
  input logic               cpu_gt_i,
  input logic               cpu_irq_i,
  input logic               cpu_int_inh_i,
  input logic               cpu_int_en_i,
  input logic               cpu_user_i
);
  assert_init_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_init_o |=> !cpu_init_o);

  assert_req_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));

  assert_no_mem_running_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_run_o |-> !mem_req_o);

  assert_stop_at_boundary_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cpu_run_o) |-> $past(cpu_instr_done_i));

  assert_start_runs_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_start_o |-> cpu_run_o);

  assert_status_layout_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (disp_sel_i == 3'd1) |-> data_lamp_o[WORD_W-1:FIELD_W] ==
      {cpu_link_i, cpu_gt_i, cpu_irq_i, cpu_int_inh_i, cpu_int_en_i, cpu_user_i, ema_lamp_o});
endmodule

bind console_panel console_panel_chk #(
  .WORD_W (WORD_W),
  .FIELD_W(FIELD_W),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .mem_req_o       (mem_req_o),
  .mem_we_o        (mem_we_o),
  .mem_addr_o      (mem_addr_o),
  .mem_ack_i       (mem_ack_i),
  .cpu_run_o       (cpu_run_o),
  .cpu_start_o     (cpu_start_o),
  .cpu_init_o      (cpu_init_o),
  .cpu_instr_done_i(cpu_instr_done_i),
  .disp_sel_i      (disp_sel_i),
  .data_lamp_o     (data_lamp_o),
  .ema_lamp_o      (ema_lamp_o),
  .cpu_link_i      (cpu_link_i),
  .cpu_gt_i        (cpu_gt_i),
  .cpu_irq_i       (cpu_irq_i),
  .cpu_int_inh_i   (cpu_int_inh_i),
  .cpu_int_en_i    (cpu_int_en_i),
  .cpu_user_i      (cpu_user_i)
);

// File: tb/tb_console_panel.sv
`timescale 1ns/1ps
module tb_console_panel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] sw = '0;
  logic [6:0]  key = '0;
  logic        sstep = 1'b0, lock = 1'b0;
  logic [2:0]  disp = 3'd3;
  logic        mem_req, mem_we, mem_ack = 1'b0;
  logic [14:0] mem_addr;
  logic [11:0] mem_wdata, mem_rdata = '0;
  logic        run, start, init, done = 1'b0;
  logic [11:0] pc;
  logic [11:0] st = '0, ac = '0, mq = '0, bus = '0;
  logic        link = 0, gt = 0, irq = 0, inh = 0, ien = 0, usr = 0;
  logic [11:0] dlamp, alamp;
  logic [2:0]  ema;
  logic        rlamp;

  int n_tests = 0, n_fail = 0;
  int n_init = 0, n_start = 0, n_req = 0, cyc = 0;
  logic req_prev = 1'b0;
  logic [11:0] mem [int];

  logic [11:0] e_cma = '0, e_md = '0;
  logic [2:0]  e_if = '0, e_df = '0;

  always #2 clk = ~clk;

  console_panel dut (
    .clk_i(clk), .rst_ni(rst_n), .sw_i(sw), .key_i(key), .sstep_i(sstep), .lock_i(lock),
    .disp_sel_i(disp), .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .mem_ack_i(mem_ack),
    .cpu_run_o(run), .cpu_start_o(start), .cpu_pc_o(pc), .cpu_init_o(init),
    .cpu_instr_done_i(done), .cpu_state_i(st), .cpu_link_i(link), .cpu_gt_i(gt),
    .cpu_irq_i(irq), .cpu_int_inh_i(inh), .cpu_int_en_i(ien), .cpu_user_i(usr),
    .cpu_ac_i(ac), .cpu_mq_i(mq), .cpu_bus_i(bus), .data_lamp_o(dlamp),
    .addr_lamp_o(alamp), .ema_lamp_o(ema), .run_lamp_o(rlamp)
  );

  function automatic logic [11:0] mem_rd(int a);
    if (mem.exists(a)) return mem[a];
    return 12'((a * 37 + 11) ^ (a >> 3));
  endfunction

  // memory responder: one-cycle ack, read data registered with it
  always @(posedge clk) begin
    if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      if (mem_we) mem[int'(mem_addr)] = mem_wdata;
      mem_rdata <= mem_rd(int'(mem_addr));
    end else begin
      mem_ack <= 1'b0;
    end
    if (init) n_init++;
    if (start) n_start++;
    if (mem_req && !req_prev) n_req++;
    req_prev <= mem_req;
    cyc++;
  end

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  always @(posedge clk) if (cyc > 150000) begin
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual cycle %0d expected < 150000", cyc);
    finish_run();
  end

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic press(int k, int hold = 12);
    @(negedge clk); key[k] = 1'b1;
    repeat (hold) @(negedge clk);
    key[k] = 1'b0;
    repeat (14) @(negedge clk);
  endtask

  task automatic check_regs(string req);
    disp = 3'd3; #1;
    check({req, " addr"}, 16'(alamp), 16'(e_cma));
    check({req, " ema"}, 16'(ema), 16'(e_if));
    check({req, " md"}, 16'(dlamp), 16'(e_md));
    disp = 3'd1; #1;
    check({req, " df"}, 16'(dlamp[2:0]), 16'(e_df));
    disp = 3'd3;
  endtask

  task automatic op_addr(logic [11:0] v);
    sw = v; press(0); e_cma = v;
  endtask
  task automatic op_extd(logic [11:0] v);
    sw = v; press(1); e_if = v[5:3]; e_df = v[2:0];
  endtask
  task automatic op_exam();
    e_md = mem_rd(int'({e_if, e_cma})); press(4); e_cma = e_cma + 1'b1;
  endtask
  task automatic op_dep(logic [11:0] v);
    sw = v; press(5); e_md = v; e_cma = e_cma + 1'b1;
  endtask

  task automatic instr_done();
    @(negedge clk); done = 1'b1;
    @(negedge clk); done = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    check("R1 reset run", 16'(rlamp), 16'd0);
    check("R1 reset req", 16'(mem_req), 16'd0);
    check_regs("R1 reset");

    op_addr(12'o1234);  check_regs("R1 addr load");
    op_extd(12'b000000110011); check_regs("R2 extd load");
    check("R2 if=6", 16'(ema), 16'd6);

    op_addr(12'o7777);
    op_exam();          check_regs("R3 exam wrap");
    check("R3 wrap to 0", 16'(alamp), 16'd0);

    op_addr(12'o0100);
    op_dep(12'o4321);   check_regs("R4 deposit");
    op_addr(12'o0100);
    op_exam();          check_regs("R4 readback");
    check("R4 readback value", 16'(e_md), 16'o4321);

    begin
      int i0 = n_init;
      sw = 12'o0555; press(2);
      check("R5 one init pulse", 16'(n_init - i0), 16'd1);
      check_regs("R5 clear keeps regs");
    end

    // short glitch and long hold
    begin
      int r0;
      sw = 12'o3333; press(0, 2);
      check_regs("R11 glitch ignored");
      r0 = n_req;
      e_md = mem_rd(int'({e_if, e_cma}));
      press(4, 60); e_cma = e_cma + 1'b1;
      check("R11 one req per hold", 16'(n_req - r0), 16'd1);
      check_regs("R11 long hold");
    end

    // lock
    lock = 1'b1; repeat (4) @(negedge clk);
    sw = 12'o0707; press(0); press(1); press(4);
    check_regs("R9 locked keys");
    press(3);
    check("R9 locked cont", 16'(rlamp), 16'd0);
    lock = 1'b0; repeat (4) @(negedge clk);

    // continue
    begin
      int s0 = n_start, r0;
      press(3);
      check("R6 run lamp", 16'(rlamp), 16'd1);
      check("R6 one start", 16'(n_start - s0), 16'd1);
      check("R6 start pc", 16'(pc), 16'(e_cma));
      r0 = n_req;
      sw = 12'o6666; press(0); press(4); press(5); press(1);
      check("R10 no req running", 16'(n_req - r0), 16'd0);
      check_regs("R10 keys ignored running");
      instr_done();
      check("R8 no halt yet", 16'(rlamp), 16'd1);
      press(6);
      check("R8 halt waits boundary", 16'(rlamp), 16'd1);
      instr_done();
      check("R8 halted at boundary", 16'(rlamp), 16'd0);
    end

    // single step
    sstep = 1'b1; repeat (4) @(negedge clk);
    press(3);
    check("R7 step running", 16'(rlamp), 16'd1);
    instr_done();
    check("R7 step stops", 16'(rlamp), 16'd0);
    sstep = 1'b0; repeat (4) @(negedge clk);

    // lamps
    for (int i = 0; i < 8; i++) begin
      logic [11:0] exp;
      {link, gt, irq, inh, ien, usr} = 6'($urandom);
      st = 12'($urandom); ac = 12'($urandom); mq = 12'($urandom); bus = 12'($urandom);
      disp = 3'd1; #1;
      check("R12 status", 16'(dlamp), 16'({link, gt, irq, inh, ien, usr, e_if, e_df}));
      for (int m = 0; m < 8; m++) begin
        if (m == 1) continue;
        disp = 3'(m); #1;
        case (m)
          0: exp = st; 2: exp = ac; 3: exp = e_md; 4: exp = mq; 5: exp = bus;
          default: exp = '0;
        endcase
        check("R13 mode", 16'(dlamp), 16'(exp));
      end
      @(negedge clk);
    end
    disp = 3'd3;

    // random mix
    for (int i = 0; i < 40; i++) begin
      logic [11:0] v = 12'($urandom);
      case ($urandom % 4)
        0: begin op_addr(v); check_regs("R1 random"); end
        1: begin op_extd(v); check_regs("R2 random"); end
        2: begin op_exam();  check_regs("R3 random"); end
        default: begin op_dep(v); check_regs("R4 random"); end
      endcase
    end

    finish_run();
  end
endmodule